// File: doc/BRIEF.md
# Invalidation Queue Descriptor Engine

This block is the hardware consumer of a ring of invalidation commands that software keeps in memory for an I/O remapping unit. Software puts 16-byte descriptors into a 256-entry ring. It programs the ring's base address and enables the engine. It then publishes new work by moving the tail pointer. The engine reads descriptors one at a time, from its head pointer up to the tail. For each one it pulses an invalidation strobe toward the matching cache and holds it until that cache acknowledges.

A wait descriptor makes the engine store a 32-bit word to a memory address that software chose. Software polls that word to learn that all earlier commands have finished. Because the engine works strictly in order, the store is issued only after every earlier strobe has been acknowledged.

The controller has seven states:

- OFF: disabled.
- IDLE: enabled, waiting for work.
- FETCH: memory read outstanding.
- DECODE: classify the latched descriptor.
- INVAL: strobe held until it is acknowledged.
- WRITE: status store held until it is acknowledged.
- HALT: stopped on a bad descriptor.

Its transitions are:

- OFF to IDLE when the enable bit is set.
- IDLE to OFF when the enable bit is clear. The head is reset to zero on this transition.
- IDLE to FETCH when head differs from tail.
- FETCH to DECODE on read data.
- DECODE to INVAL for the four cache types.
- DECODE to WRITE for a wait descriptor that requests a store.
- DECODE to IDLE for a wait descriptor without a store. The head advances.
- DECODE to HALT for any other type.
- INVAL to IDLE on acknowledge. The head advances.
- WRITE to IDLE on acknowledge. The head advances.
- HALT to OFF when the enable bit is cleared. The head is reset to zero.

Top module: `iq_engine`

## Requirements
- R1: After reset the head, tail, base, command, status and completion-status registers all read zero, and no fetch, strobe or store is requested.
- R2: The tail register (offset 0x88) stores the index from write-data bits 11:4 and reads back as index shifted left by 4. The head register (offset 0x80) reads as index shifted left by 4 and ignores writes.
- R3: Bit 26 of the command register (offset 0x18) requests enable. Bit 26 of the status register (offset 0x1C) is still 0 in the cycle after the command write and reads 1 from the following cycle.
- R4: A fetch is requested only while head differs from tail. Its address is base plus head times 16. Read data bits 63:0 are the lower descriptor word and bits 127:64 the upper word.
- R5: Descriptor type (lower word bits 3:0) 1, 2, 3 or 4 drives strobe bit 0, 1, 2 or 3 respectively, one-hot. The strobe is held until the acknowledge arrives, and the head advances by one after the acknowledge.
- R6: While the type-4 strobe is up, the selective flag carries lower-word bit 4, the entry index carries bits 47:32 and the index mask carries bits 31:27.
- R7: A type-5 descriptor with lower-word bit 5 set issues one store of lower-word bits 63:32 to the address held in the upper word. With bit 5 clear, no store is issued and the head still advances.
- R8: A store is never requested while a strobe or a fetch is outstanding, so it follows the acknowledgement of every earlier descriptor.
- R9: The head wraps from index 255 to index 0, and fetch addresses wrap with it.
- R10: Clearing the enable bit lets a descriptor in progress finish, then resets the head to zero, clears status bit 26 and stops fetching.
- R11: A write to the base register (offset 0x90) is ignored while the engine is enabled or still active.
- R12: Any other type sets sticky bit 1 of the completion-status register (offset 0x98) and halts the engine without advancing the head. Writing 1 to that bit clears it; writing 0 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr (combinational) |
| mrd_req | output | 1 | Descriptor read request, held until mrd_rvalid |
| mrd_addr | output | 64 | Descriptor byte address |
| mrd_rvalid | input | 1 | Read data valid |
| mrd_rdata | input | 128 | Descriptor read data |
| mwr_req | output | 1 | Status store request, held until mwr_ack |
| mwr_addr | output | 64 | Status store address |
| mwr_data | output | 32 | Status store data |
| mwr_ack | input | 1 | Status store accepted |
| inv_strobe | output | 4 | One-hot invalidation request (context, IOTLB, device IOTLB, interrupt entry) |
| inv_ack | input | 1 | Invalidation acknowledge |
| iec_selective | output | 1 | Interrupt-entry invalidation is selective |
| iec_index | output | 16 | Interrupt-entry index |
| iec_mask | output | 5 | Interrupt-entry index mask |

## Verification
A corrupted head pointer shows up at the very next fetch. The read address moves off base plus 16 times the index, and the head register reads a value that no longer matches the count of descriptors consumed.

A wrong decode shows up in the same descriptor's cycles. The wrong strobe bit rises, a store appears where none was asked for, or the error bit sets on a legal type.

An ordering fault is visible within one cycle as a store overlapping a strobe or a fetch. A lost disable shows up as fetches continuing after the descriptor in progress has been acknowledged.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam logic [7:0] OFS_CMD  = 8'h18;
    localparam logic [7:0] OFS_STS  = 8'h1C;
    localparam logic [7:0] OFS_HEAD = 8'h80;
    localparam logic [7:0] OFS_TAIL = 8'h88;
    localparam logic [7:0] OFS_BASE = 8'h90;
    localparam logic [7:0] OFS_ICS  = 8'h98;

    localparam int EN_BIT  = 26;
    localparam int ERR_BIT = 1;
    localparam int STW_BIT = 5;
    localparam int SEL_BIT = 4;

    typedef enum logic [2:0] {
        KIND_CC, KIND_IOTLB, KIND_DEVTLB, KIND_IEC, KIND_WAIT, KIND_BAD
    } kind_e;

    typedef enum logic [2:0] {
        ST_OFF, ST_IDLE, ST_FETCH, ST_DECODE, ST_INVAL, ST_WRITE, ST_HALT
    } state_e;

    typedef struct packed {
        kind_e       kind;
        logic        wr_req;
        logic [31:0] wr_data;
        logic [63:0] wr_addr;
        logic        iec_sel;
        logic [15:0] iec_idx;
        logic [4:0]  iec_mask;
    } dinfo_t;
endpackage

// File: rtl/iq_decode.sv
module iq_decode
    import iq_pkg::*;
(
    input  logic [127:0] desc_i,
    output dinfo_t       info_o
);
    logic [63:0] lo;
    logic [63:0] hi;
    logic        unused_lo;

    assign lo        = desc_i[63:0];
    assign hi        = desc_i[127:64];
    assign unused_lo = ^lo[26:6];

    always_comb begin
        unique case (lo[3:0])
            4'd1:    info_o.kind = KIND_CC;
            4'd2:    info_o.kind = KIND_IOTLB;
            4'd3:    info_o.kind = KIND_DEVTLB;
            4'd4:    info_o.kind = KIND_IEC;
            4'd5:    info_o.kind = KIND_WAIT;
            default: info_o.kind = KIND_BAD;
        endcase
        info_o.wr_req   = lo[STW_BIT];
        info_o.wr_data  = lo[63:32];
        info_o.wr_addr  = hi;
        info_o.iec_sel  = lo[SEL_BIT];
        info_o.iec_idx  = lo[47:32];
        info_o.iec_mask = lo[31:27];
    end
endmodule

// File: rtl/iq_regfile.sv
module iq_regfile
    import iq_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [7:0]       addr_i,
    input  logic [63:0]      wdata_i,
    output logic [63:0]      rdata_o,
    input  logic [IDX_W-1:0] head_i,
    input  logic             active_i,
    input  logic             err_set_i,
    output logic [IDX_W-1:0] tail_o,
    output logic [63:0]      base_o,
    output logic             en_o
);
    logic [IDX_W-1:0] tail_q;
    logic [63:0]      base_q;
    logic             en_q;
    logic             err_q;
    logic             locked;
    logic             err_clr;

    assign locked  = en_q | active_i;
    assign err_clr = we_i && addr_i == OFS_ICS && wdata_i[ERR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail_q <= '0;
            base_q <= '0;
            en_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (we_i && addr_i == OFS_TAIL) tail_q <= wdata_i[IDX_W+3:4];
            if (we_i && addr_i == OFS_BASE && !locked) base_q <= wdata_i;
            if (we_i && addr_i == OFS_CMD) en_q <= wdata_i[EN_BIT];
            if (err_set_i) err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_HEAD: rdata_o = 64'({head_i, 4'b0000});
            OFS_TAIL: rdata_o = 64'({tail_q, 4'b0000});
            OFS_BASE: rdata_o = base_q;
            OFS_ICS:  rdata_o[ERR_BIT] = err_q;
            OFS_CMD:  rdata_o[EN_BIT] = en_q;
            OFS_STS:  rdata_o[EN_BIT] = active_i;
            default:  rdata_o = '0;
        endcase
    end

    assign tail_o = tail_q;
    assign base_o = base_q;
    assign en_o   = en_q;

    AST_BASE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == OFS_BASE && locked) |=> $stable(base_q)); // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q); // R12
    AST_ACTIVE_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_i) |-> $past(en_q)); // R3
endmodule

// File: rtl/iq_ctrl.sv
module iq_ctrl
    import iq_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [IDX_W-1:0] tail_i,
    input  logic [63:0]      base_i,
    output logic [IDX_W-1:0] head_o,
    output logic             active_o,
    output logic             err_set_o,
    output logic             mrd_req,
    output logic [63:0]      mrd_addr,
    input  logic             mrd_rvalid,
    input  logic [127:0]     mrd_rdata,
    output logic             mwr_req,
    output logic [63:0]      mwr_addr,
    output logic [31:0]      mwr_data,
    input  logic             mwr_ack,
    output logic [3:0]       inv_strobe,
    input  logic             inv_ack,
    output logic             iec_selective,
    output logic [15:0]      iec_index,
    output logic [4:0]       iec_mask
);
    state_e           state_q, state_d;
    logic [IDX_W-1:0] head_q;
    logic [127:0]     desc_q;
    dinfo_t           info;
    logic             advance;
    logic             go_off;

    iq_decode u_decode (.desc_i(desc_q), .info_o(info));

    always_comb begin
        state_d = state_q;
        advance = 1'b0;
        unique case (state_q)
            ST_OFF:    if (en_i) state_d = ST_IDLE;
            ST_IDLE:   if (!en_i) state_d = ST_OFF;
                       else if (head_q != tail_i) state_d = ST_FETCH;
            ST_FETCH:  if (mrd_rvalid) state_d = ST_DECODE;
            ST_DECODE: begin
                unique case (info.kind)
                    KIND_CC, KIND_IOTLB, KIND_DEVTLB, KIND_IEC: state_d = ST_INVAL;
                    KIND_WAIT: begin
                        if (info.wr_req) state_d = ST_WRITE;
                        else begin
                            state_d = ST_IDLE;
                            advance = 1'b1;
                        end
                    end
                    default: state_d = ST_HALT;
                endcase
            end
            ST_INVAL:  if (inv_ack) begin
                           state_d = ST_IDLE;
                           advance = 1'b1;
                       end
            ST_WRITE:  if (mwr_ack) begin
                           state_d = ST_IDLE;
                           advance = 1'b1;
                       end
            ST_HALT:   if (!en_i) state_d = ST_OFF;
            default:   state_d = ST_OFF;
        endcase
    end

    assign go_off = (state_q == ST_IDLE || state_q == ST_HALT) && !en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            head_q  <= '0;
            desc_q  <= '0;
        end else begin
            state_q <= state_d;
            if (go_off) head_q <= '0;
            else if (advance) head_q <= head_q + 1'b1;
            if (state_q == ST_FETCH && mrd_rvalid) desc_q <= mrd_rdata;
        end
    end

    always_comb begin
        mrd_req       = state_q == ST_FETCH;
        mrd_addr      = base_i + 64'({head_q, 4'b0000});
        mwr_req       = state_q == ST_WRITE;
        mwr_addr      = info.wr_addr;
        mwr_data      = info.wr_data;
        inv_strobe    = (state_q == ST_INVAL) ? 4'(4'b0001 << info.kind) : 4'b0000;
        iec_selective = info.iec_sel;
        iec_index     = info.iec_idx;
        iec_mask      = info.iec_mask;
        err_set_o     = state_q == ST_DECODE && info.kind == KIND_BAD;
        active_o      = state_q != ST_OFF;
    end

    assign head_o = head_q;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inv_strobe)); // R5
    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_strobe != 4'b0000 && !inv_ack) |=> $stable(inv_strobe)); // R5
    AST_WRITE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        mwr_req |-> (inv_strobe == 4'b0000 && !mrd_req)); // R8
    AST_FETCH_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mrd_req) |-> $past(head_q != tail_i)); // R4
    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (head_q != $past(head_q)) |-> (head_q == IDX_W'($past(head_q) + 1'b1) || head_q == '0)); // R9
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && en_i) |=> $stable(head_q)); // R12
endmodule

// File: rtl/iq_engine.sv
module iq_engine
    import iq_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [7:0]    reg_addr,
    input  logic [63:0]   reg_wdata,
    output logic [63:0]   reg_rdata,
    output logic          mrd_req,
    output logic [63:0]   mrd_addr,
    input  logic          mrd_rvalid,
    input  logic [127:0]  mrd_rdata,
    output logic          mwr_req,
    output logic [63:0]   mwr_addr,
    output logic [31:0]   mwr_data,
    input  logic          mwr_ack,
    output logic [3:0]    inv_strobe,
    input  logic          inv_ack,
    output logic          iec_selective,
    output logic [15:0]   iec_index,
    output logic [4:0]    iec_mask
);
    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] tail;
    logic [63:0]      base;
    logic             en;
    logic             active;
    logic             err_set;

    iq_regfile #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata), .head_i(head),
        .active_i(active), .err_set_i(err_set), .tail_o(tail),
        .base_o(base), .en_o(en)
    );

    iq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en_i(en), .tail_i(tail), .base_i(base),
        .head_o(head), .active_o(active), .err_set_o(err_set),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_rvalid(mrd_rvalid),
        .mrd_rdata(mrd_rdata), .mwr_req(mwr_req), .mwr_addr(mwr_addr),
        .mwr_data(mwr_data), .mwr_ack(mwr_ack), .inv_strobe(inv_strobe),
        .inv_ack(inv_ack), .iec_selective(iec_selective),
        .iec_index(iec_index), .iec_mask(iec_mask)
    );
endmodule

// File: tb/test_iq_engine.sv
`timescale 1ns/1ps
module test_iq_engine;
    localparam logic [63:0] BASE = 64'h0000_0000_1000_0000;
    localparam logic [7:0] A_CMD = 8'h18, A_STS = 8'h1C, A_HEAD = 8'h80,
                           A_TAIL = 8'h88, A_BASE = 8'h90, A_ICS = 8'h98;
    localparam logic [63:0] EN = 64'h1 << 26;

    typedef struct packed {
        logic [63:0] lo;
        logic [63:0] hi;
        logic [2:0]  kind;
        logic [31:0] data;
        logic [21:0] iec;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{64'h1, 64'h0, 3'd1, 32'h0, 22'h0},
        '{64'hFFFF_0000_0000_0002, 64'h0, 3'd2, 32'h0, 22'h0},
        '{64'h3, 64'h0, 3'd3, 32'h0, 22'h0},
        '{64'h4, 64'h0, 3'd4, 32'h0, 22'h0},
        '{64'h0000_1234_D800_0014, 64'h0, 3'd4, 32'h0, {1'b1, 16'h1234, 5'h1B}},
        '{64'hCAFE_F00D_0000_0025, 64'h0000_0000_8000_0040, 3'd5, 32'hCAFE_F00D, 22'h0},
        '{64'h5, 64'h0, 3'd0, 32'h0, 22'h0},
        '{64'h2, 64'h0, 3'd2, 32'h0, 22'h0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h0;
    logic [63:0] reg_wdata = 64'h0;
    logic [63:0] reg_rdata;
    logic mrd_req, mwr_req, iec_selective;
    logic [63:0] mrd_addr, mwr_addr;
    logic mrd_rvalid = 1'b0;
    logic [127:0] mrd_rdata = '0;
    logic [31:0] mwr_data;
    logic mwr_ack = 1'b0;
    logic [3:0] inv_strobe;
    logic inv_ack = 1'b0;
    logic [15:0] iec_index;
    logic [4:0] iec_mask;

    iq_engine i_iq_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mrd_req(mrd_req),
        .mrd_addr(mrd_addr), .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
        .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data),
        .mwr_ack(mwr_ack), .inv_strobe(inv_strobe), .inv_ack(inv_ack),
        .iec_selective(iec_selective), .iec_index(iec_index), .iec_mask(iec_mask)
    );

    always #4 clk = ~clk;

    logic [127:0] mem [256];
    int checks = 0, failures = 0;
    int ack_delay = 2, ack_cnt = 0;
    int ev_cnt = 0, fetch_cnt = 0, overlap = 0;
    int last_kind = 0;
    logic [31:0] last_data = '0;
    logic [63:0] last_waddr = '0, last_fetch = '0;
    logic [21:0] last_iec = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory, cache and store responders
    initial begin
        forever begin
            @(negedge clk);
            mrd_rvalid = mrd_req;
            if (mrd_req) begin
                fetch_cnt++;
                last_fetch = mrd_addr;
                mrd_rdata = mem[8'((mrd_addr - BASE) >> 4)];
            end
            if (inv_strobe != 4'b0000) begin
                if (ack_cnt >= ack_delay) begin
                    inv_ack = 1'b1;
                    ack_cnt = 0;
                end else begin
                    inv_ack = 1'b0;
                    ack_cnt++;
                end
            end else begin
                inv_ack = 1'b0;
                ack_cnt = 0;
            end
            mwr_ack = mwr_req;
            if (mwr_req && (inv_strobe != 4'b0000 || mrd_req)) overlap++;
            if (inv_strobe != 4'b0000 && inv_ack) begin
                ev_cnt++;
                for (int b = 0; b < 4; b++) if (inv_strobe[b]) last_kind = b + 1;
                last_iec = {iec_selective, iec_index, iec_mask};
            end
            if (mwr_req) begin
                ev_cnt++;
                last_kind = 5;
                last_data = mwr_data;
                last_waddr = mwr_addr;
            end
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_head(input int idx, input int limit);
        logic [63:0] h;
        for (int n = 0; n < limit; n++) begin
            reg_read(A_HEAD, h);
            if (h == 64'(idx) << 4) break;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] v;
        int ev0, f0;
        for (int k = 0; k < 256; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(A_HEAD, v); chk(v == 0, "R1 head", v, 0);
        reg_read(A_TAIL, v); chk(v == 0, "R1 tail", v, 0);
        reg_read(A_BASE, v); chk(v == 0, "R1 base", v, 0);
        reg_read(A_CMD, v);  chk(v == 0, "R1 cmd", v, 0);
        reg_read(A_STS, v);  chk(v == 0, "R1 sts", v, 0);
        reg_read(A_ICS, v);  chk(v == 0, "R1 ics", v, 0);
        chk(!mrd_req && !mwr_req && inv_strobe == 0, "R1 outputs", {mrd_req, mwr_req, inv_strobe}, 0);

        // R2 head ignores writes, tail reads back shifted
        reg_write(A_HEAD, 64'h50);
        reg_read(A_HEAD, v); chk(v == 0, "R2 head write ignored", v, 0);
        reg_write(A_TAIL, 64'h0);
        reg_write(A_BASE, BASE);
        reg_read(A_BASE, v); chk(v == BASE, "R11 base load while off", v, BASE);

        // R3 enable handshake
        reg_write(A_CMD, EN);
        reg_addr = A_STS;
        #1 chk(reg_rdata[26] == 1'b0, "R3 status not yet active", reg_rdata, 0);
        @(negedge clk);
        #1 chk(reg_rdata[26] == 1'b1, "R3 status active", reg_rdata, EN);

        // R11 base locked while enabled
        reg_write(A_BASE, 64'hDEAD_0000);
        reg_read(A_BASE, v); chk(v == BASE, "R11 base write ignored", v, BASE);

        // table of descriptors: R4 R5 R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            mem[i] = {VECS[i].hi, VECS[i].lo};
            ev0 = ev_cnt;
            reg_write(A_TAIL, 64'(i + 1) << 4);
            wait_head(i + 1, 60);
            reg_read(A_TAIL, v); chk(v == 64'(i + 1) << 4, "R2 tail readback", v, 64'(i + 1) << 4);
            reg_read(A_HEAD, v); chk(v == 64'(i + 1) << 4, "R5 head advance", v, 64'(i + 1) << 4);
            chk(last_fetch == BASE + 64'(i) * 16, "R4 fetch address", last_fetch, BASE + 64'(i) * 16);
            if (VECS[i].kind == 3'd0) begin
                chk(ev_cnt == ev0, "R7 no store without bit 5", 64'(ev_cnt), 64'(ev0));
            end else begin
                chk(ev_cnt == ev0 + 1 && last_kind == int'(VECS[i].kind), "R5 event kind",
                    64'(last_kind), 64'(VECS[i].kind));
                if (VECS[i].kind == 3'd4)
                    chk(last_iec == VECS[i].iec, "R6 iec fields", 64'(last_iec), 64'(VECS[i].iec));
                if (VECS[i].kind == 3'd5) begin
                    chk(last_data == VECS[i].data, "R7 store data", 64'(last_data), 64'(VECS[i].data));
                    chk(last_waddr == VECS[i].hi, "R7 store address", last_waddr, VECS[i].hi);
                end
            end
        end
        chk(overlap == 0, "R8 store overlap", 64'(overlap), 0);

        // R9 wrap past 255
        for (int k = 8; k < 256; k++) mem[k] = {64'h0, 64'h5};
        for (int k = 0; k < 4; k++) mem[k] = {64'h0, 64'h5};
        reg_write(A_TAIL, 64'h40);
        wait_head(4, 3000);
        reg_read(A_HEAD, v); chk(v == 64'h40, "R9 head wrapped", v, 64'h40);
        chk(last_fetch == BASE + 64'h30, "R9 fetch address wrapped", last_fetch, BASE + 64'h30);

        // R10 disable mid-descriptor
        mem[4] = {64'h0, 64'h2};
        mem[5] = {64'h0, 64'h1};
        ack_delay = 10;
        reg_write(A_TAIL, 64'h60);
        for (int n = 0; n < 40 && inv_strobe == 4'b0000; n++) @(negedge clk);
        reg_write(A_CMD, 64'h0);
        chk(inv_strobe == 4'b0010, "R10 strobe held after disable", 64'(inv_strobe), 64'h2);
        for (int n = 0; n < 40; n++) begin
            reg_read(A_STS, v);
            if (v[26] == 1'b0) break;
        end
        chk(v[26] == 1'b0, "R10 status inactive", v, 0);
        chk(last_kind == 2, "R10 descriptor finished", 64'(last_kind), 2);
        reg_read(A_HEAD, v); chk(v == 0, "R10 head reset", v, 0);
        f0 = fetch_cnt;
        repeat (20) @(negedge clk);
        chk(fetch_cnt == f0, "R10 no fetch after disable", 64'(fetch_cnt), 64'(f0));
        ack_delay = 2;

        // R12 unknown type halts with sticky error
        reg_write(A_TAIL, 64'h0);
        mem[0] = {64'h0, 64'h7};
        reg_write(A_CMD, EN);
        f0 = fetch_cnt;
        reg_write(A_TAIL, 64'h10);
        repeat (20) @(negedge clk);
        reg_read(A_ICS, v); chk(v == 64'h2, "R12 error set", v, 64'h2);
        reg_read(A_HEAD, v); chk(v == 0, "R12 head held", v, 0);
        chk(fetch_cnt == f0 + 1, "R12 halted after one fetch", 64'(fetch_cnt), 64'(f0 + 1));
        reg_write(A_ICS, 64'h0);
        reg_read(A_ICS, v); chk(v == 64'h2, "R12 write 0 keeps error", v, 64'h2);
        reg_write(A_CMD, 64'h0);
        repeat (3) @(negedge clk);
        reg_read(A_STS, v); chk(v == 0, "R12 halt left by disable", v, 0);
        reg_write(A_ICS, 64'h2);
        reg_read(A_ICS, v); chk(v == 0, "R12 write 1 clears error", v, 0);

        finish_run();
    end
endmodule